// File: doc/BRIEF.md
# Multi-Flag Doorbell Channel Bank

This block holds a bank of doorbell channels shared by a sending agent and a receiving agent. Every channel is a word of 32 event flags, and each flag is a one-bit transfer of its own. The sender raises events by writing a set mask. The receiver sees pending events through a level interrupt for each channel, reads the flag word and retires events by writing a clear mask. When a clear retires a flag that was pending, an acknowledge bit is latched for the sender. That bit drives a per-channel acknowledge interrupt until the sender writes a one to it to clear it.

Each side has a single-cycle write port and a combinational read port, both addressed by channel index and a register select. A read-only register gives the channel count so that software can find out the size of the bank at run time. A combined interrupt is the OR of every receiver and sender interrupt. Register writes are plain strobes with no back-pressure: a write takes effect at the clock edge on which `*_wr_en` is high, and it is never refused.

Top module: `dbell_bank`

## Requirements
- R1: After a synchronous reset (`rst` high at a rising edge), every flag, mask bit and acknowledge bit is 0, and all interrupt outputs are low.
- R2: A sender write with select 0 (set) ORs the written word into the addressed channel's flags. 0 bits leave their flags as they were, and several flags can be raised in one write.
- R3: A receiver write with select 0 (clear) clears each flag whose data bit is 1 and leaves the other flags untouched.
- R4: If a set and a clear hit the same flag in the same cycle, the set wins. The flag stays 1 and no acknowledge is produced for that flag.
- R5: `rcv_irq[c]` is high while channel c has a pending flag whose mask bit is 0. A receiver write with select 1 loads the mask word, where a 1 hides the flag.
- R6: A clear that retires a pending flag sets the matching acknowledge bit of that channel. A clear of a flag that is not pending leaves the acknowledge bits unchanged.
- R7: A sender write with select 1 clears the acknowledge bits written as 1. A new acknowledge on the same bit in the same cycle wins.
- R8: `ack_irq[c]` is high while any acknowledge bit of channel c is set.
- R9: `irq_any` is the OR of all `rcv_irq` and `ack_irq` bits.
- R10: Read select 2 returns the channel count NUM_CH on both sides. Read select 0 returns flags on both sides. Read select 1 returns the acknowledge bits on the sender side and the mask on the receiver side. Read select 3 returns 0.
- R11: Writes addressed to a channel index of NUM_CH or above have no effect, and reads of such an index return 0.
- R12: A write to one channel never changes the state of another channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| snd_wr_en | input | 1 | Sender write strobe |
| snd_wr_sel | input | 1 | Sender write select: 0 set flags, 1 clear acknowledge bits |
| snd_wr_ch | input | IDX_W | Sender write channel index |
| snd_wr_data | input | FLAGS | Sender write data |
| snd_rd_ch | input | IDX_W | Sender read channel index |
| snd_rd_sel | input | 2 | Sender read select |
| snd_rd_data | output | FLAGS | Sender read data |
| rcv_wr_en | input | 1 | Receiver write strobe |
| rcv_wr_sel | input | 1 | Receiver write select: 0 clear flags, 1 load mask |
| rcv_wr_ch | input | IDX_W | Receiver write channel index |
| rcv_wr_data | input | FLAGS | Receiver write data |
| rcv_rd_ch | input | IDX_W | Receiver read channel index |
| rcv_rd_sel | input | 2 | Receiver read select |
| rcv_rd_data | output | FLAGS | Receiver read data |
| rcv_irq | output | NUM_CH | Per-channel receiver transfer interrupt |
| ack_irq | output | NUM_CH | Per-channel sender acknowledge interrupt |
| irq_any | output | 1 | Combined interrupt |

## Verification
The bench targets the same-cycle collisions. A set racing a clear on one flag must leave the flag raised with no acknowledge; a design where the clear wins would lose the event and report a false acknowledge. An acknowledge clear racing a fresh acknowledge must keep the new bit; a design that gets this wrong would drop a completion. The bench also checks that clearing a flag that is not pending produces no acknowledge, that a mask hides the interrupt while the flag stays pending, and that writes to an index past the bank are ignored. A design that decodes only the low index bits would alias such a write onto a real channel.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam logic       WR_PRIMARY = 1'b0;  // sender: set flags, receiver: clear flags
  localparam logic       WR_AUX     = 1'b1;  // sender: clear ack bits, receiver: load mask
  localparam logic [1:0] RD_FLAGS   = 2'd0;
  localparam logic [1:0] RD_AUX     = 2'd1;  // sender: ack bits, receiver: mask
  localparam logic [1:0] RD_COUNT   = 2'd2;
  localparam logic [1:0] RD_NONE    = 2'd3;
endpackage

// File: rtl/dbell_chan.sv
module dbell_chan #(
  parameter int FLAGS = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_we,
  input  logic [FLAGS-1:0] set_bits,
  input  logic             clr_we,
  input  logic [FLAGS-1:0] clr_bits,
  input  logic             mask_we,
  input  logic [FLAGS-1:0] mask_bits,
  input  logic             ackclr_we,
  input  logic [FLAGS-1:0] ackclr_bits,
  output logic [FLAGS-1:0] flags,
  output logic [FLAGS-1:0] mask,
  output logic [FLAGS-1:0] ack,
  output logic             rcv_irq,
  output logic             ack_irq
);
  logic [FLAGS-1:0] set_v, clr_v, ackclr_v, retired;

  always_comb begin
    set_v    = set_we    ? set_bits    : '0;
    clr_v    = clr_we    ? clr_bits    : '0;
    ackclr_v = ackclr_we ? ackclr_bits : '0;
    // a flag counts as retired only if it was pending and no set races the clear
    retired  = flags & clr_v & ~set_v;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      flags <= '0;
      mask  <= '0;
      ack   <= '0;
    end else begin
      flags <= (flags & ~clr_v) | set_v;
      ack   <= (ack & ~ackclr_v) | retired;
      if (mask_we) mask <= mask_bits;
    end
  end

  assign rcv_irq = |(flags & ~mask);
  assign ack_irq = |ack;
endmodule

// File: rtl/dbell_rd_mux.sv
module dbell_rd_mux #(
  parameter int NUM_CH = 4,
  parameter int FLAGS  = 32,
  parameter int IDX_W  = 7
) (
  input  logic [IDX_W-1:0]             ch,
  input  logic [1:0]                   sel,
  input  logic [NUM_CH-1:0][FLAGS-1:0] flags_arr,
  input  logic [NUM_CH-1:0][FLAGS-1:0] aux_arr,
  output logic [FLAGS-1:0]             data
);
  import dbell_pkg::*;
  localparam int CH_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;

  logic            in_range;
  logic [CH_W-1:0] idx;

  always_comb begin
    in_range = 32'(ch) < NUM_CH;
    idx      = CH_W'(ch);
    data     = '0;
    case (sel)
      RD_FLAGS: if (in_range) data = flags_arr[idx];
      RD_AUX:   if (in_range) data = aux_arr[idx];
      RD_COUNT: data = FLAGS'(NUM_CH);
      default:  data = '0;
    endcase
  end
endmodule

// File: rtl/dbell_bank.sv
module dbell_bank #(
  parameter int NUM_CH = 4,
  parameter int FLAGS  = 32,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              snd_wr_en,
  input  logic              snd_wr_sel,
  input  logic [IDX_W-1:0]  snd_wr_ch,
  input  logic [FLAGS-1:0]  snd_wr_data,
  input  logic [IDX_W-1:0]  snd_rd_ch,
  input  logic [1:0]        snd_rd_sel,
  output logic [FLAGS-1:0]  snd_rd_data,
  input  logic              rcv_wr_en,
  input  logic              rcv_wr_sel,
  input  logic [IDX_W-1:0]  rcv_wr_ch,
  input  logic [FLAGS-1:0]  rcv_wr_data,
  input  logic [IDX_W-1:0]  rcv_rd_ch,
  input  logic [1:0]        rcv_rd_sel,
  output logic [FLAGS-1:0]  rcv_rd_data,
  output logic [NUM_CH-1:0] rcv_irq,
  output logic [NUM_CH-1:0] ack_irq,
  output logic              irq_any
);
  import dbell_pkg::*;

  logic [NUM_CH-1:0][FLAGS-1:0] flag_vec, mask_vec, ack_vec;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic snd_hit, rcv_hit;
    assign snd_hit = snd_wr_en && (32'(snd_wr_ch) == c);
    assign rcv_hit = rcv_wr_en && (32'(rcv_wr_ch) == c);

    dbell_chan #(.FLAGS(FLAGS)) u_chan (
      .clk         (clk),
      .rst         (rst),
      .set_we      (snd_hit && snd_wr_sel == WR_PRIMARY),
      .set_bits    (snd_wr_data),
      .clr_we      (rcv_hit && rcv_wr_sel == WR_PRIMARY),
      .clr_bits    (rcv_wr_data),
      .mask_we     (rcv_hit && rcv_wr_sel == WR_AUX),
      .mask_bits   (rcv_wr_data),
      .ackclr_we   (snd_hit && snd_wr_sel == WR_AUX),
      .ackclr_bits (snd_wr_data),
      .flags       (flag_vec[c]),
      .mask        (mask_vec[c]),
      .ack         (ack_vec[c]),
      .rcv_irq     (rcv_irq[c]),
      .ack_irq     (ack_irq[c])
    );
  end

  dbell_rd_mux #(.NUM_CH(NUM_CH), .FLAGS(FLAGS), .IDX_W(IDX_W)) u_snd_rd (
    .ch        (snd_rd_ch),
    .sel       (snd_rd_sel),
    .flags_arr (flag_vec),
    .aux_arr   (ack_vec),
    .data      (snd_rd_data)
  );

  dbell_rd_mux #(.NUM_CH(NUM_CH), .FLAGS(FLAGS), .IDX_W(IDX_W)) u_rcv_rd (
    .ch        (rcv_rd_ch),
    .sel       (rcv_rd_sel),
    .flags_arr (flag_vec),
    .aux_arr   (mask_vec),
    .data      (rcv_rd_data)
  );

  assign irq_any = |{rcv_irq, ack_irq};
endmodule

// File: rtl/dbell_bank_chk.sv
module dbell_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int FLAGS  = 32,
  parameter int IDX_W  = 7
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         snd_wr_en,
  input logic                         snd_wr_sel,
  input logic [IDX_W-1:0]             snd_wr_ch,
  input logic [FLAGS-1:0]             snd_wr_data,
  input logic                         rcv_wr_en,
  input logic                         rcv_wr_sel,
  input logic [IDX_W-1:0]             rcv_wr_ch,
  input logic [1:0]                   snd_rd_sel,
  input logic [FLAGS-1:0]             snd_rd_data,
  input logic [NUM_CH-1:0]            rcv_irq,
  input logic [NUM_CH-1:0]            ack_irq,
  input logic                         irq_any,
  input logic [NUM_CH-1:0][FLAGS-1:0] flag_vec
);
  // R9: combined output tracks the per-channel sources
  p_combined_r9: assert property (@(posedge clk) disable iff (rst)
    irq_any == (|rcv_irq || |ack_irq));

  // R10: discovery register
  p_count_r10: assert property (@(posedge clk) disable iff (rst)
    (snd_rd_sel == 2'd2) |-> (snd_rd_data == FLAGS'(NUM_CH)));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R2 / R4: every bit written by a set is raised next cycle, even under a racing clear
    p_set_wins_r4: assert property (@(posedge clk) disable iff (rst)
      (snd_wr_en && snd_wr_sel == 1'b0 && snd_wr_ch == IDX_W'(c))
        |=> ((flag_vec[c] & $past(snd_wr_data)) == $past(snd_wr_data)));

    // R5: receiver interrupt only rises after a set or a mask load on this channel
    p_irq_cause_r5: assert property (@(posedge clk) disable iff (rst)
      $rose(rcv_irq[c]) |->
        ($past(snd_wr_en && snd_wr_sel == 1'b0 && snd_wr_ch == IDX_W'(c)) ||
         $past(rcv_wr_en && rcv_wr_sel == 1'b1 && rcv_wr_ch == IDX_W'(c))));

    // R6: acknowledge only rises after a receiver clear on this channel
    p_ack_cause_r6: assert property (@(posedge clk) disable iff (rst)
      $rose(ack_irq[c]) |->
        $past(rcv_wr_en && rcv_wr_sel == 1'b0 && rcv_wr_ch == IDX_W'(c)));

    // R7 / R8: acknowledge persists until the sender clears it
    p_ack_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (ack_irq[c] && !(snd_wr_en && snd_wr_sel == 1'b1 && snd_wr_ch == IDX_W'(c)))
        |=> ack_irq[c]);
  end
endmodule

bind dbell_bank dbell_bank_chk #(.NUM_CH(NUM_CH), .FLAGS(FLAGS), .IDX_W(IDX_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .snd_wr_en   (snd_wr_en),
  .snd_wr_sel  (snd_wr_sel),
  .snd_wr_ch   (snd_wr_ch),
  .snd_wr_data (snd_wr_data),
  .rcv_wr_en   (rcv_wr_en),
  .rcv_wr_sel  (rcv_wr_sel),
  .rcv_wr_ch   (rcv_wr_ch),
  .snd_rd_sel  (snd_rd_sel),
  .snd_rd_data (snd_rd_data),
  .rcv_irq     (rcv_irq),
  .ack_irq     (ack_irq),
  .irq_any     (irq_any),
  .flag_vec    (flag_vec)
);

// File: tb/test_dbell_bank.sv
module test_dbell_bank;
  localparam int NUM_CH = 4;
  localparam int FLAGS  = 32;
  localparam int IDX_W  = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic snd_wr_en = 1'b0, snd_wr_sel = 1'b0;
  logic [IDX_W-1:0] snd_wr_ch = '0, snd_rd_ch = '0;
  logic [FLAGS-1:0] snd_wr_data = '0;
  logic [1:0] snd_rd_sel = 2'd0;
  logic [FLAGS-1:0] snd_rd_data;
  logic rcv_wr_en = 1'b0, rcv_wr_sel = 1'b0;
  logic [IDX_W-1:0] rcv_wr_ch = '0, rcv_rd_ch = '0;
  logic [FLAGS-1:0] rcv_wr_data = '0;
  logic [1:0] rcv_rd_sel = 2'd0;
  logic [FLAGS-1:0] rcv_rd_data;
  logic [NUM_CH-1:0] rcv_irq, ack_irq;
  logic irq_any;

  int total = 0;
  int bad   = 0;

  always #4 clk = ~clk;  // 125 MHz

  dbell_bank #(.NUM_CH(NUM_CH), .FLAGS(FLAGS), .IDX_W(IDX_W)) i_dbell_bank (
    .clk(clk), .rst(rst),
    .snd_wr_en(snd_wr_en), .snd_wr_sel(snd_wr_sel), .snd_wr_ch(snd_wr_ch),
    .snd_wr_data(snd_wr_data), .snd_rd_ch(snd_rd_ch), .snd_rd_sel(snd_rd_sel),
    .snd_rd_data(snd_rd_data),
    .rcv_wr_en(rcv_wr_en), .rcv_wr_sel(rcv_wr_sel), .rcv_wr_ch(rcv_wr_ch),
    .rcv_wr_data(rcv_wr_data), .rcv_rd_ch(rcv_rd_ch), .rcv_rd_sel(rcv_rd_sel),
    .rcv_rd_data(rcv_rd_data),
    .rcv_irq(rcv_irq), .ack_irq(ack_irq), .irq_any(irq_any)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one write on either side, or both in the same cycle
  task automatic wr(bit s_en, logic s_sel, int s_ch, logic [31:0] s_d,
                    bit r_en, logic r_sel, int r_ch, logic [31:0] r_d);
    @(negedge clk);
    snd_wr_en = s_en; snd_wr_sel = s_sel; snd_wr_ch = IDX_W'(s_ch); snd_wr_data = s_d;
    rcv_wr_en = r_en; rcv_wr_sel = r_sel; rcv_wr_ch = IDX_W'(r_ch); rcv_wr_data = r_d;
    @(negedge clk);
    snd_wr_en = 1'b0; rcv_wr_en = 1'b0;
  endtask

  task automatic snd_set(int ch, logic [31:0] d);    wr(1, 1'b0, ch, d, 0, 1'b0, 0, 0); endtask
  task automatic snd_ackclr(int ch, logic [31:0] d); wr(1, 1'b1, ch, d, 0, 1'b0, 0, 0); endtask
  task automatic rcv_clr(int ch, logic [31:0] d);    wr(0, 1'b0, 0, 0, 1, 1'b0, ch, d); endtask
  task automatic rcv_mask(int ch, logic [31:0] d);   wr(0, 1'b0, 0, 0, 1, 1'b1, ch, d); endtask

  function automatic logic [31:0] snd_rd(int ch, logic [1:0] sel);
    return 32'(0);
  endfunction

  task automatic rd_snd(int ch, logic [1:0] sel, output logic [31:0] d);
    snd_rd_ch = IDX_W'(ch); snd_rd_sel = sel; #1; d = snd_rd_data;
  endtask
  task automatic rd_rcv(int ch, logic [1:0] sel, output logic [31:0] d);
    rcv_rd_ch = IDX_W'(ch); rcv_rd_sel = sel; #1; d = rcv_rd_data;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    for (int c = 0; c < NUM_CH; c++) begin
      rd_snd(c, 2'd0, d); chk("R1 flags", d, 0);
      rd_snd(c, 2'd1, d); chk("R1 ack", d, 0);
      rd_rcv(c, 2'd1, d); chk("R1 mask", d, 0);
    end
    chk("R1 irqs", {rcv_irq, ack_irq, irq_any}, 0);
  endtask

  task automatic t_set();
    logic [31:0] d;
    snd_set(1, 32'h0000_00A5);
    snd_set(1, 32'h0100_0000);
    rd_rcv(1, 2'd0, d); chk("R2 multi set", d, 32'h0100_00A5);
    chk("R5 rcv_irq", 32'(rcv_irq), 32'h2);
    rd_rcv(0, 2'd0, d); chk("R12 other channel", d, 0);
    chk("R9 combined", 32'(irq_any), 1);
  endtask

  task automatic t_clear();
    logic [31:0] d;
    rcv_clr(1, 32'h0000_0005);
    rd_rcv(1, 2'd0, d); chk("R3 clear", d, 32'h0100_00A0);
    rd_snd(1, 2'd1, d); chk("R6 ack latched", d, 32'h5);
    chk("R8 ack_irq", 32'(ack_irq), 32'h2);
    rcv_clr(1, 32'h0000_0002);
    rd_snd(1, 2'd1, d); chk("R6 idle clear no ack", d, 32'h5);
  endtask

  task automatic t_ack_w1c();
    logic [31:0] d;
    snd_ackclr(1, 32'h1);
    rd_snd(1, 2'd1, d); chk("R7 partial w1c", d, 32'h4);
    chk("R8 ack_irq held", 32'(ack_irq), 32'h2);
    snd_ackclr(1, 32'h4);
    rd_snd(1, 2'd1, d); chk("R7 full w1c", d, 0);
    chk("R8 ack_irq low", 32'(ack_irq), 0);
  endtask

  task automatic t_race();
    logic [31:0] d;
    snd_set(2, 32'h18);
    wr(1, 1'b0, 2, 32'h08, 1, 1'b0, 2, 32'h18);
    rd_rcv(2, 2'd0, d); chk("R4 set wins", d, 32'h08);
    rd_snd(2, 2'd1, d); chk("R4 no ack on raced flag", d, 32'h10);
    snd_set(2, 32'h10);
    wr(1, 1'b1, 2, 32'h10, 1, 1'b0, 2, 32'h10);
    rd_snd(2, 2'd1, d); chk("R7 new ack wins", d, 32'h10);
    rd_rcv(2, 2'd0, d); chk("R3 raced clear", d, 32'h08);
  endtask

  task automatic t_mask();
    logic [31:0] d;
    rcv_mask(3, 32'h1);
    snd_set(3, 32'h1);
    chk("R5 masked", 32'(rcv_irq[3]), 0);
    rd_rcv(3, 2'd0, d); chk("R5 flag pending", d, 32'h1);
    rd_rcv(3, 2'd1, d); chk("R10 mask read", d, 32'h1);
    rcv_mask(3, 32'h0);
    chk("R5 unmasked", 32'(rcv_irq[3]), 1);
  endtask

  task automatic t_drain();
    for (int c = 0; c < NUM_CH; c++) rcv_clr(c, 32'hFFFF_FFFF);
    for (int c = 0; c < NUM_CH; c++) snd_ackclr(c, 32'hFFFF_FFFF);
    chk("R9 all quiet", {rcv_irq, ack_irq, irq_any}, 0);
  endtask

  task automatic t_count_range();
    logic [31:0] d;
    rd_snd(0, 2'd2, d); chk("R10 count snd", d, NUM_CH);
    rd_rcv(0, 2'd2, d); chk("R10 count rcv", d, NUM_CH);
    rd_snd(0, 2'd3, d); chk("R10 unused sel", d, 0);
    snd_set(NUM_CH + 1, 32'hFFFF_FFFF);
    snd_set(NUM_CH + 4, 32'hFFFF_FFFF);
    chk("R11 out of range set", {rcv_irq, irq_any}, 0);
    rd_rcv(NUM_CH + 1, 2'd0, d); chk("R11 out of range read", d, 0);
    for (int c = 0; c < NUM_CH; c++) begin
      rd_rcv(c, 2'd0, d); chk("R11 no alias", d, 0);
    end
  endtask

  initial begin
    #(8 * 100000);
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_set();
    t_clear();
    t_ack_w1c();
    t_race();
    t_mask();
    t_drain();
    t_count_range();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule